// File: doc/BRIEF.md
# Half-Cycle Elastic Buffer Occupancy Monitor

This block watches the fill level of an elastic buffer that carries words from a recovered write clock to a local read clock. The two clocks have the same nominal frequency but drift slowly against each other. The block owns the write and read addresses of that buffer. It also keeps a second copy of each address, taken on the falling edge of its own clock. Two comparisons run in the read domain. The first relates the rising-edge read address to a two-flop synchronized, Gray-coded rising-edge write address. The second relates the falling-edge read address to a synchronized falling-edge write address. The sum of the two differences is an occupancy estimate counted in half words, so drift is seen after about half a clock period rather than a full word.

From this estimate the block derives one of four levels. The read side acts on the level by inserting a fill word (read address held for a cycle) or by dropping one (read address advanced by two). A low-band delete request becomes a high-band request if occupancy keeps rising before the deletion takes effect. Storing the words and muxing the data path are handled outside this block.

Top module: `elocc_monitor`

## Requirements
- R1: `wr_addr` advances by one, modulo DEPTH, on each `wr_clk` rising edge where `wr_inc` is high, and is otherwise unchanged.
- R2: on each `rd_clk` rising edge `rd_addr` advances modulo DEPTH by the amount coded on `rd_step`: 0 holds it (fill inserted), 1 advances by one, 2 advances by two (word dropped), and 3 is treated as 1.
- R3: `occ_half` is the sum of the rising-pair and falling-pair word differences. After both addresses have been still for 6 read cycles it equals 2 × (writes − reads).
- R4: `level` is coded 0 = add wait (`occ_half` < 2·HOLD_WORDS), 1 = hold (equal to 2·HOLD_WORDS), 2 = low delete wait (above hold and below 2·HIGH_WORDS), 3 = high delete wait (at least 2·HIGH_WORDS). Level and requests are registered on `rd_clk`.
- R5: `add_req` is high exactly when `level` is add wait.
- R6: `del_lo_req` is high exactly when `level` is low delete wait.
- R7: `del_hi_req` is high exactly when `level` is high delete wait. When occupancy rises out of the low band, `del_lo_req` drops and `del_hi_req` rises.
- R8: while the resets are asserted, both addresses and `occ_half` are 0, `level` is hold (1), and no request is raised.
- R9: the classification depends only on occupancy and not on where in the address range the two addresses sit, across every wrap position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (recovered) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_inc | input | 1 | A word is written this cycle |
| rd_clk | input | 1 | Read (local) clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_step | input | 2 | Read advance: 0 fill, 1 normal, 2 skip, 3 as 1 |
| wr_addr | output | $clog2(DEPTH) | Buffer write address |
| rd_addr | output | $clog2(DEPTH) | Buffer read address |
| occ_half | output | $clog2(DEPTH)+2 | Occupancy estimate in half words |
| level | output | 2 | Occupancy level code |
| add_req | output | 1 | Request to insert a fill word |
| del_lo_req | output | 1 | Low-band request to drop a fill word |
| del_hi_req | output | 1 | High-band request to drop a fill word |

## Verification
A corrupted address or synchronizer stage makes `occ_half` differ from twice the true word count no more than three read cycles after the pointers go still. That same error moves `level` and the request lines into the wrong band. A falling-edge copy that is stuck or taken from the wrong edge shows up as an odd `occ_half` in a quiet buffer. A wrong step decode shows as a drift of `rd_addr` away from the count of reads issued, and that drift persists over every later wrap of the address.

// File: rtl/elocc_pkg.sv
package elocc_pkg;

    // Ordered by rising occupancy; the read side decodes this order.
    typedef enum logic [1:0] {
        LVL_ADD    = 2'd0,
        LVL_HOLD   = 2'd1,
        LVL_DEL_LO = 2'd2,
        LVL_DEL_HI = 2'd3
    } occ_level_e;

endpackage

// File: rtl/elocc_sync.sv
module elocc_sync #(
    parameter int unsigned W        = 4,
    parameter bit          NEG_EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] last;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d.meta = d;
        s_d.last = s_q.meta;
    end

    generate
        if (NEG_EDGE) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end
        end
    endgenerate

    assign q = s_q.last;

endmodule

// File: rtl/elocc_wr_ptrs.sv
module elocc_wr_ptrs #(
    parameter int unsigned AW = 3,
    localparam int unsigned PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_inc,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] gray_rise,
    output logic [PW-1:0] gray_fall
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] fall_d, fall_q;

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + PW'(wr_inc);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        fall_d    = st_q.gray;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) st_q <= '0;
        else           st_q <= st_d;
    end

    // Half-cycle copy of the write pointer; never used to address storage.
    always_ff @(negedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) fall_q <= '0;
        else           fall_q <= fall_d;
    end

    assign wr_addr   = st_q.bin[AW-1:0];
    assign gray_rise = st_q.gray;
    assign gray_fall = fall_q;

    // R1: one step per accepted write
    a_r1_wr_advance: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_inc |=> st_q.bin == $past(st_q.bin) + PW'(1));

    // R1: no write, no movement
    a_r1_wr_still: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_inc |=> $stable(st_q.bin));

endmodule

// File: rtl/elocc_rd_side.sv
module elocc_rd_side
    import elocc_pkg::*;
#(
    parameter int unsigned AW         = 3,
    parameter int unsigned HOLD_WORDS = 3,
    parameter int unsigned HIGH_WORDS = 5,
    localparam int unsigned PW = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic [1:0]    rd_step,
    input  logic [PW-1:0] wgray_rise,
    input  logic [PW-1:0] wgray_fall,
    output logic [AW-1:0] rd_addr,
    output logic [PW:0]   occ_half,
    output occ_level_e    level,
    output logic          add_req,
    output logic          del_lo_req,
    output logic          del_hi_req
);

    localparam logic [PW:0] HOLD_HALF = (PW+1)'(2 * HOLD_WORDS);
    localparam logic [PW:0] HIGH_HALF = (PW+1)'(2 * HIGH_WORDS);

    typedef struct packed {
        logic [PW-1:0] rd_bin;
        logic [PW:0]   occ_half;
        occ_level_e    level;
        logic          add;
        logic          del_lo;
        logic          del_hi;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] fall_d, fall_q;
    logic [PW-1:0] wb_rise, wb_fall, occ_rise, occ_fall;
    logic [1:0]    adv;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        case (rd_step)
            2'd0:    adv = 2'd0;
            2'd2:    adv = 2'd2;
            default: adv = 2'd1;
        endcase

        wb_rise  = gray_to_bin(wgray_rise);
        wb_fall  = gray_to_bin(wgray_fall);
        occ_rise = wb_rise - st_q.rd_bin;
        occ_fall = wb_fall - fall_q;

        st_d          = st_q;
        st_d.rd_bin   = st_q.rd_bin + PW'(adv);
        st_d.occ_half = {1'b0, occ_rise} + {1'b0, occ_fall};

        if (st_d.occ_half < HOLD_HALF)       st_d.level = LVL_ADD;
        else if (st_d.occ_half == HOLD_HALF) st_d.level = LVL_HOLD;
        else if (st_d.occ_half < HIGH_HALF)  st_d.level = LVL_DEL_LO;
        else                                 st_d.level = LVL_DEL_HI;

        st_d.add    = (st_d.level == LVL_ADD);
        st_d.del_lo = (st_d.level == LVL_DEL_LO);
        st_d.del_hi = (st_d.level == LVL_DEL_HI);

        fall_d = st_q.rd_bin;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            st_q       <= '0;
            st_q.level <= LVL_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // Falling-edge read pointer copy; only feeds the second comparison.
    always_ff @(negedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) fall_q <= '0;
        else           fall_q <= fall_d;
    end

    assign rd_addr    = st_q.rd_bin[AW-1:0];
    assign occ_half   = st_q.occ_half;
    assign level      = st_q.level;
    assign add_req    = st_q.add;
    assign del_lo_req = st_q.del_lo;
    assign del_hi_req = st_q.del_hi;

    // R2: read pointer moves by at most two locations per cycle
    a_r2_rd_step_range: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        PW'(st_q.rd_bin - $past(st_q.rd_bin)) <= PW'(2));

    // R3: falling copy taken half a cycle after the rising pointer settled
    a_r3_fall_copy: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        fall_q == st_q.rd_bin);

    // R3: the synchronized write pointer moves one Gray bit at a time
    a_r3_gray_one_bit: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(wgray_rise ^ $past(wgray_rise)) <= 1);

    // R5: add request only below the hold point
    a_r5_add_band: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        add_req |-> occ_half < HOLD_HALF);

    // R6: low delete request only inside the low band
    a_r6_low_band: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        del_lo_req |-> (occ_half > HOLD_HALF) && (occ_half < HIGH_HALF));

    // R7: high delete request only at or above the high threshold
    a_r7_high_band: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        del_hi_req |-> occ_half >= HIGH_HALF);

    // R4: hold level carries no request
    a_r4_hold_quiet: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (level == LVL_HOLD) |-> !(add_req || del_lo_req || del_hi_req));

endmodule

// File: rtl/elocc_monitor.sv
module elocc_monitor
    import elocc_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned HOLD_WORDS = 3,
    parameter int unsigned HIGH_WORDS = 5,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_inc,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic [1:0]    rd_step,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [PW:0]   occ_half,
    output logic [1:0]    level,
    output logic          add_req,
    output logic          del_lo_req,
    output logic          del_hi_req
);

    logic [PW-1:0] wgray_rise, wgray_fall;
    logic [PW-1:0] wgray_rise_s, wgray_fall_s;
    occ_level_e    level_w;

    elocc_wr_ptrs #(.AW(AW)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_inc   (wr_inc),
        .wr_addr  (wr_addr),
        .gray_rise(wgray_rise),
        .gray_fall(wgray_fall)
    );

    elocc_sync #(.W(PW), .NEG_EDGE(1'b0)) u_sync_rise (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .d    (wgray_rise),
        .q    (wgray_rise_s)
    );

    elocc_sync #(.W(PW), .NEG_EDGE(1'b1)) u_sync_fall (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .d    (wgray_fall),
        .q    (wgray_fall_s)
    );

    elocc_rd_side #(
        .AW        (AW),
        .HOLD_WORDS(HOLD_WORDS),
        .HIGH_WORDS(HIGH_WORDS)
    ) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_step   (rd_step),
        .wgray_rise(wgray_rise_s),
        .wgray_fall(wgray_fall_s),
        .rd_addr   (rd_addr),
        .occ_half  (occ_half),
        .level     (level_w),
        .add_req   (add_req),
        .del_lo_req(del_lo_req),
        .del_hi_req(del_hi_req)
    );

    assign level = level_w;

endmodule

// File: tb/test_elocc_monitor.sv
module test_elocc_monitor;

    localparam int DEPTH = 8;
    localparam int HOLDW = 3;
    localparam int HIGHW = 5;
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_inc = 1'b0;
    logic [1:0]    rd_step = 2'd1;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW:0]   occ_half;
    logic [1:0]    level;
    logic          add_req, del_lo_req, del_hi_req;

    int nchk = 0;
    int nerr = 0;
    int wc = 0;
    int rc = 0;
    bit done = 1'b0;

    elocc_monitor #(.DEPTH(DEPTH), .HOLD_WORDS(HOLDW), .HIGH_WORDS(HIGHW)) i_elocc_monitor (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_inc(wr_inc),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_step(rd_step),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .occ_half(occ_half),
        .level(level), .add_req(add_req), .del_lo_req(del_lo_req),
        .del_hi_req(del_hi_req)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d (writes=%0d reads=%0d)",
                     req, act, exp, wc, rc);
        end
    endtask

    task automatic do_write();
        @(negedge wr_clk) wr_inc = 1'b1;
        @(negedge wr_clk) wr_inc = 1'b0;
        wc++;
    endtask

    task automatic do_read(input int code);
        @(negedge rd_clk) rd_step = 2'(code);
        @(negedge rd_clk) rd_step = 2'd0;
        rc += (code == 0) ? 0 : ((code == 2) ? 2 : 1);
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    function automatic int exp_level(input int half);
        if (half < 2 * HOLDW)       return 0;
        else if (half == 2 * HOLDW) return 1;
        else if (half < 2 * HIGHW)  return 2;
        else                        return 3;
    endfunction

    task automatic check_all(input string ctx);
        int occ, half, lv;
        occ  = wc - rc;
        half = 2 * occ;
        lv   = exp_level(half);
        chk({"R1 wr_addr ", ctx}, int'(wr_addr), wc % DEPTH);
        chk({"R2 rd_addr ", ctx}, int'(rd_addr), rc % DEPTH);
        chk({"R3 occ_half ", ctx}, int'(occ_half), half);
        chk({"R4 R9 level ", ctx}, int'(level), lv);
        chk({"R5 add_req ", ctx}, int'(add_req), int'(lv == 0));
        chk({"R6 del_lo_req ", ctx}, int'(del_lo_req), int'(lv == 2));
        chk({"R7 del_hi_req ", ctx}, int'(del_hi_req), int'(lv == 3));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rd_step = 2'd0;
        repeat (4) @(negedge rd_clk);
        // R8: state while reset is held
        chk("R8 wr_addr in reset", int'(wr_addr), 0);
        chk("R8 rd_addr in reset", int'(rd_addr), 0);
        chk("R8 occ_half in reset", int'(occ_half), 0);
        chk("R8 level in reset", int'(level), 1);
        chk("R8 requests in reset", int'({add_req, del_lo_req, del_hi_req}), 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        settle();
        check_all("after reset");

        // R2: step code 0 holds, code 3 acts as a single step
        do_write(); do_write();
        settle();
        check_all("two written");
        do_read(0);
        settle();
        check_all("R2 fill insert code 0");
        do_read(3);
        settle();
        check_all("R2 code 3");
        do_read(1);
        settle();
        check_all("drained");

        // R9: sweep every occupancy at every pointer base
        for (int round = 0; round < 2 * DEPTH; round++) begin
            for (int k = 1; k <= DEPTH; k++) begin
                do_write();
                settle();
                check_all("R7 rising sweep");
            end
            for (int t = 0; wc - rc > 0; t++) begin
                do_read(((wc - rc) >= 2 && (t % 2 == 0)) ? 2 : 1);
                settle();
                check_all("falling sweep");
            end
            do_write();
            do_read(1);
            settle();
            check_all("R9 base shift");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule